// File: doc/BRIEF.md
# Split-Byte Conversion Result Holder with Read Lock

This block keeps the latest 10-bit conversion result and serves it over an 8-bit read bus as two bytes: an upper byte and a lower byte. Software reads the upper byte first and the lower byte second. The upper-byte read locks the pair, so a conversion that finishes between the two reads cannot mix an old upper byte with a new lower byte.

A conversion that finishes while the pair is locked is thrown away. It is not queued. A sticky lost flag records the drop, and the next lower-byte read clears it. An 8-bit mode removes the lock entirely. Every completion then updates the holder, the lower byte carries the 8-bit result, and the upper byte reads zero.

If a completion arrives in the same cycle as the unlocking lower-byte read, it is held for one cycle and then loaded. The read itself returns the old value.

Top module: `adc_result_interlock`

## Requirements
- R1: In 10-bit mode, a read at the upper-byte address (default 0) returns result bits 9:8 in data bits 1:0, and data bits 7:2 read 0.
- R2: A read at the lower-byte address (default 1) returns result bits 7:0. A read at any other address returns 0, sets no lock and clears nothing.
- R3: When the pair is unlocked, a completion pulse loads `conv_result`. The new value can be read from the cycle after the pulse.
- R4: In 10-bit mode, an upper-byte read sets the lock. A completion that arrives in the same cycle as that read, or while the lock is set, does not change either byte.
- R5: A lower-byte read clears the lock. A completion in any later cycle loads normally.
- R6: A completion dropped under the lock is discarded. After unlocking, both bytes still hold the value from before the lock.
- R7: `lost_flag` goes to 1 in the cycle after a completion is dropped. A lower-byte read clears it on the next edge.
- R8: When `mode8` is 1, upper-byte reads set no lock and every completion loads. The lower byte then returns `conv_result[7:0]`, and the upper byte returns 0.
- R9: If a completion coincides with a lower-byte read, the read returns the old value. When locked, the new value is readable two cycles after that read. When unlocked, it is readable one cycle after.
- R10: After reset, both bytes read 0, the lock is clear and `lost_flag` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode8 | input | 1 | 1 selects 8-bit result mode (no lock) |
| conv_done | input | 1 | One-cycle completion pulse from the converter |
| conv_result | input | 10 | Result word, valid with `conv_done` |
| rd_en | input | 1 | Read strobe, one cycle per access |
| rd_addr | input | ADDR_W | Read address |
| rd_data | output | 8 | Read data, combinational from the held value |
| lost_flag | output | 1 | Sticky flag: a completion was dropped under the lock |

## Verification
The assertions take for granted that `rd_en` is a single-cycle strobe per access. They also assume `mode8` does not change between an upper-byte read and the matching lower-byte read. They assume a held completion is not overtaken by a new pulse in the very next cycle. The stimulus changes `mode8` only while the pair is unlocked. It always leaves at least one idle cycle after a completion that coincides with a locked lower-byte read. It drives all inputs on the falling edge.

// File: rtl/adcrr_pkg.sv
package adcrr_pkg;
  localparam int RES_W  = 10;
  localparam int BYTE_W = 8;
  localparam int TOP_W  = RES_W - BYTE_W;

  // Value stored on a load: in 8-bit mode only the low byte is kept.
  function automatic logic [RES_W-1:0] stored_word(input logic m8,
                                                   input logic [RES_W-1:0] raw);
    stored_word = m8 ? {{TOP_W{1'b0}}, raw[BYTE_W-1:0]} : raw;
  endfunction

  function automatic logic [BYTE_W-1:0] upper_byte(input logic [RES_W-1:0] w);
    upper_byte = {{(BYTE_W-TOP_W){1'b0}}, w[RES_W-1:BYTE_W]};
  endfunction

  function automatic logic [BYTE_W-1:0] lower_byte(input logic [RES_W-1:0] w);
    lower_byte = w[BYTE_W-1:0];
  endfunction
endpackage

// File: rtl/rr_read_port.sv
module rr_read_port
  import adcrr_pkg::*;
#(
  parameter int ADDR_W  = 2,
  parameter int HI_ADDR = 0,
  parameter int LO_ADDR = 1
) (
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic [RES_W-1:0]  held_word,
  output logic              hi_rd,
  output logic              lo_rd,
  output logic [BYTE_W-1:0] rd_data
);
  localparam logic [ADDR_W-1:0] HI_A = ADDR_W'(HI_ADDR);
  localparam logic [ADDR_W-1:0] LO_A = ADDR_W'(LO_ADDR);

  assign hi_rd = rd_en && (rd_addr == HI_A);
  assign lo_rd = rd_en && (rd_addr == LO_A);

  always_comb begin
    if (hi_rd)      rd_data = upper_byte(held_word);
    else if (lo_rd) rd_data = lower_byte(held_word);
    else            rd_data = '0;
  end
endmodule

// File: rtl/rr_lock_ctrl.sv
module rr_lock_ctrl
  import adcrr_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             mode8,
  input  logic             hi_rd,
  input  logic             lo_rd,
  input  logic             conv_done,
  input  logic [RES_W-1:0] conv_result,
  output logic             load,
  output logic [RES_W-1:0] load_raw,
  output logic             lock_q,
  output logic             lost_q
);
  logic             pend_q;
  logic [RES_W-1:0] pend_word_q;
  logic             comp_v;
  logic             eff_lock;
  logic             drop;
  logic             defer;

  // A held completion re-enters through the same path; a fresh pulse wins.
  assign comp_v   = conv_done | pend_q;
  assign load_raw = conv_done ? conv_result : pend_word_q;
  // An upper-byte read locks already in its own cycle.
  assign eff_lock = lock_q | (hi_rd & ~mode8);
  assign load     = comp_v & ~eff_lock;
  assign defer    = comp_v & eff_lock & lo_rd;
  assign drop     = comp_v & eff_lock & ~lo_rd;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lock_q      <= 1'b0;
      lost_q      <= 1'b0;
      pend_q      <= 1'b0;
      pend_word_q <= '0;
    end else begin
      if (mode8 || lo_rd) lock_q <= 1'b0;
      else if (hi_rd)     lock_q <= 1'b1;

      if (lo_rd)     lost_q <= 1'b0;
      else if (drop) lost_q <= 1'b1;

      pend_q <= defer;
      if (defer) pend_word_q <= load_raw;
    end
  end

  p_lock_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (hi_rd && !mode8) |=> lock_q);
  p_lock_clr_r5: assert property (@(posedge clk) disable iff (!rst_n)
    lo_rd |=> !lock_q);
  p_no_lock_r8: assert property (@(posedge clk) disable iff (!rst_n)
    mode8 |=> !lock_q);
  p_lost_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
    drop |=> lost_q);
  p_lost_clr_r7: assert property (@(posedge clk) disable iff (!rst_n)
    lo_rd |=> !lost_q);
  p_defer_load_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (defer && !hi_rd) |=> (pend_q && (conv_done || !hi_rd) -> load));
endmodule

// File: rtl/rr_result_store.sv
module rr_result_store
  import adcrr_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             mode8,
  input  logic [RES_W-1:0] load_raw,
  output logic [RES_W-1:0] held_word
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    held_word <= '0;
    else if (load) held_word <= stored_word(mode8, load_raw);
  end

  p_idle_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable(held_word));
endmodule

// File: rtl/adc_result_interlock.sv
module adc_result_interlock
  import adcrr_pkg::*;
#(
  parameter int ADDR_W  = 2,
  parameter int HI_ADDR = 0,
  parameter int LO_ADDR = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mode8,
  input  logic              conv_done,
  input  logic [9:0]        conv_result,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [7:0]        rd_data,
  output logic              lost_flag
);
  logic             hi_rd;
  logic             lo_rd;
  logic             load;
  logic [RES_W-1:0] load_raw;
  logic [RES_W-1:0] held_word;
  logic             lock_q;
  logic             lost_q;

  rr_read_port #(.ADDR_W(ADDR_W), .HI_ADDR(HI_ADDR), .LO_ADDR(LO_ADDR)) u_port (
    .rd_en(rd_en), .rd_addr(rd_addr), .held_word(held_word),
    .hi_rd(hi_rd), .lo_rd(lo_rd), .rd_data(rd_data)
  );

  rr_lock_ctrl u_lock (
    .clk(clk), .rst_n(rst_n), .mode8(mode8), .hi_rd(hi_rd), .lo_rd(lo_rd),
    .conv_done(conv_done), .conv_result(conv_result),
    .load(load), .load_raw(load_raw), .lock_q(lock_q), .lost_q(lost_q)
  );

  rr_result_store u_store (
    .clk(clk), .rst_n(rst_n), .load(load), .mode8(mode8),
    .load_raw(load_raw), .held_word(held_word)
  );

  assign lost_flag = lost_q;

  // Locked and not being unlocked: the held pair must not move.
  p_frozen_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (lock_q && !lo_rd) |=> $stable(held_word));
  // A completion in the cycle of an upper-byte read in 10-bit mode is not taken.
  p_same_cycle_hi_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (hi_rd && !mode8 && conv_done) |=> ($stable(held_word) && lost_flag));
endmodule

// File: tb/adc_result_interlock_test.sv
`timescale 1ns/1ps
module adc_result_interlock_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       mode8 = 1'b0;
  logic       conv_done = 1'b0;
  logic [9:0] conv_result = '0;
  logic       rd_en = 1'b0;
  logic [1:0] rd_addr = '0;
  logic [7:0] rd_data;
  logic       lost_flag;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  localparam logic [1:0] A_HI = 2'd0;
  localparam logic [1:0] A_LO = 2'd1;
  localparam logic [1:0] A_X  = 2'd2;

  always #10 clk = ~clk;

  adc_result_interlock uut (
    .clk(clk), .rst_n(rst_n), .mode8(mode8), .conv_done(conv_done),
    .conv_result(conv_result), .rd_en(rd_en), .rd_addr(rd_addr),
    .rd_data(rd_data), .lost_flag(lost_flag)
  );

  function automatic logic [7:0] exp_hi(input logic [9:0] v);
    return {6'b000000, v[9], v[8]};
  endfunction
  function automatic logic [7:0] exp_lo(input logic [9:0] v);
    return v & 10'h0FF;
  endfunction

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step(input logic d, input logic [9:0] r, input logic re,
                      input logic [1:0] a, output logic [7:0] q);
    @(negedge clk);
    conv_done = d; conv_result = r; rd_en = re; rd_addr = a;
    #1 q = rd_data;
    @(posedge clk);
    #1 conv_done = 1'b0; rd_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] q);
    step(1'b0, 10'h0, 1'b1, a, q);
  endtask

  task automatic cv(input logic [9:0] r);
    logic [7:0] q;
    step(1'b1, r, 1'b0, A_HI, q);
  endtask

  task automatic idle();
    logic [7:0] q;
    step(1'b0, 10'h0, 1'b0, A_HI, q);
  endtask

  task automatic t_reset();
    logic [7:0] q;
    chk("R10 lost after reset", {7'b0, lost_flag}, 8'h00);
    rd(A_HI, q); chk("R10 upper after reset", q, 8'h00);
    rd(A_LO, q); chk("R10 lower after reset", q, 8'h00);
  endtask

  task automatic t_basic();
    logic [7:0] q;
    cv(10'h2A5);
    rd(A_HI, q); chk("R1 upper of 2A5", q, exp_hi(10'h2A5));
    rd(A_LO, q); chk("R2 lower of 2A5", q, exp_lo(10'h2A5));
    cv(10'h3FF);
    rd(A_HI, q); chk("R1 upper of 3FF", q, exp_hi(10'h3FF));
    rd(A_LO, q); chk("R3 lower of 3FF", q, exp_lo(10'h3FF));
  endtask

  task automatic t_lock_drop();
    logic [7:0] q;
    cv(10'h155);
    rd(A_HI, q); chk("R4 upper before drop", q, 8'h01);
    cv(10'h2AA);
    chk("R7 lost set after drop", {7'b0, lost_flag}, 8'h01);
    rd(A_LO, q); chk("R4 lower frozen", q, 8'h55);
    chk("R7 lost cleared by lower read", {7'b0, lost_flag}, 8'h00);
    rd(A_HI, q); chk("R6 dropped value not queued upper", q, 8'h01);
    rd(A_LO, q); chk("R6 dropped value not queued lower", q, 8'h55);
    cv(10'h0F0);
    rd(A_LO, q); chk("R5 load after unlock", q, 8'hF0);
  endtask

  task automatic t_same_hi();
    logic [7:0] q;
    cv(10'h123);
    step(1'b1, 10'h3C4, 1'b1, A_HI, q);
    chk("R4 same-cycle upper returns old", q, 8'h01);
    chk("R7 same-cycle drop sets lost", {7'b0, lost_flag}, 8'h01);
    rd(A_LO, q); chk("R4 same-cycle completion not loaded", q, 8'h23);
  endtask

  task automatic t_same_lo();
    logic [7:0] q;
    cv(10'h100);
    rd(A_HI, q);
    step(1'b1, 10'h2C3, 1'b1, A_LO, q);
    chk("R9 locked same-cycle lower returns old", q, 8'h00);
    idle();
    rd(A_HI, q); chk("R9 held completion loaded upper", q, 8'h02);
    rd(A_LO, q); chk("R9 held completion loaded lower", q, 8'hC3);
    chk("R9 no loss flagged", {7'b0, lost_flag}, 8'h00);
    step(1'b1, 10'h07E, 1'b1, A_LO, q);
    chk("R9 unlocked same-cycle lower returns old", q, 8'hC3);
    rd(A_LO, q); chk("R9 unlocked new value next cycle", q, 8'h7E);
  endtask

  task automatic t_other_addr();
    logic [7:0] q;
    cv(10'h1AB);
    rd(A_X, q); chk("R2 other address reads 0", q, 8'h00);
    cv(10'h0CD);
    rd(A_LO, q); chk("R2 other address set no lock", q, 8'hCD);
    chk("R2 no loss after other address", {7'b0, lost_flag}, 8'h00);
  endtask

  task automatic t_mode8();
    logic [7:0] q;
    @(negedge clk); mode8 = 1'b1;
    cv(10'h3A7);
    rd(A_HI, q); chk("R8 upper reads 0 in 8-bit mode", q, 8'h00);
    cv(10'h012);
    chk("R8 no loss in 8-bit mode", {7'b0, lost_flag}, 8'h00);
    rd(A_LO, q); chk("R8 completion after upper read loads", q, 8'h12);
    step(1'b1, 10'h2FE, 1'b1, A_HI, q);
    rd(A_LO, q); chk("R8 same-cycle upper read does not block", q, 8'hFE);
    @(negedge clk); mode8 = 1'b0;
  endtask

  initial begin
    #(20.0 * 200000);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    t_reset();
    t_basic();
    t_lock_drop();
    t_same_hi();
    t_same_lo();
    t_other_addr();
    t_mode8();
    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule